// File: doc/BRIEF.md
# Predicated Vector Reduction Engine

This block folds a short vector of integer elements into a single value using one commutative two-operand operation: addition, multiplication, signed minimum, signed maximum or bitwise OR. The elements live in a small register file inside the engine. Software-side logic fills and inspects that file through a plain write port and a combinational read port. A one-cycle start pulse launches a reduction. The pulse carries the vector length, a per-element predicate mask, the source and destination base indices, the sub-vector width and the mode bits. The engine performs one operation per clock. When it finishes, it writes the result back into the register file and pulses `done`.

Elements whose predicate bit is clear take no part in the reduction. The result goes to the destination slot of the first enabled element, and no other register is touched. Elements can be grouped into sub-vectors of 1 to 4 lanes, and the grouping can be reduced in two ways. In the vertical way, each lane is folded across the elements on its own. In the horizontal way, the lanes of each enabled element are folded into one result for that element. An optional 4-bit condition field summarises the signed sign of the partial results. It can be read either as "some results met the criterion" or as "all results met the criterion".

Top module: `vreduce_engine`

## Requirements
- R1: The operation code selects the fold, and every result wraps modulo 2^EW. Code 0 is add, 1 is multiply (low EW bits), 2 is signed minimum, 3 is signed maximum and 4 is bitwise OR.
- R2: Codes 5, 6 and 7 are rejected. `done` and `illegal` rise together in the cycle after the start pulse, `busy` never rises, and no register changes.
- R3: An element whose bit in `pmask` (bit i for element i) is clear does not contribute to the result.
- R4: In vertical mode, lane j of the result goes to register dst_base + f*L + j, where f is the first enabled element and L is the lane count. No other register is written, including masked-out destination slots.
- R5: A start with `vlen` = 0, or with no enabled element below `vlen`, writes nothing. It pulses `done` in the next cycle with `illegal` low.
- R6: The condition field is {lt, gt, eq, so}, bits 3 down to 0. It comes from a signed comparison against zero, with so always 0. When `cr_en` is set it is presented with `cr_valid` in the cycle of each result write.
- R7: In vertical mode the field starts from the first enabled element and is replaced by the first combined result. Each later combined result is then ORed in when `cr_all` = 0, or ANDed in when `cr_all` = 1.
- R8: With `sub_len` > 0 (lane count `sub_len`+1) and `horiz` = 0, each lane is reduced independently. Element i, lane j is read from src_base + i*L + j, and `cr_valid` never rises.
- R9: With `horiz` = 1, each enabled element i has its L lanes folded in lane order and written to dst_base + i. It produces one condition field computed from that element's result.
- R10: `busy` is high from the cycle after an accepted start through the last write, and `done` is a one-cycle pulse in the following cycle with `busy` low. A run takes L*(vlen+1) busy cycles vertically. Horizontally it takes L+1 cycles per enabled element and 1 per masked element.
- R11: External register-file writes presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | External register write enable (ignored while busy) |
| wr_addr | input | AW | External write index |
| wr_data | input | EW | External write value |
| rd_addr | input | AW | Read index |
| rd_data | output | EW | Register contents at rd_addr (combinational) |
| start | input | 1 | Launch pulse, accepted when idle |
| op | input | 3 | Fold operation code |
| vlen | input | VW | Number of elements, 0..VLMAX |
| pmask | input | VLMAX | Per-element enable mask |
| src_base | input | AW | First source register |
| dst_base | input | AW | First destination register |
| sub_len | input | 2 | Lanes per element minus one |
| horiz | input | 1 | Fold lanes within each element |
| cr_en | input | 1 | Produce condition fields |
| cr_all | input | 1 | 1: AND-accumulate, 0: OR-accumulate |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Rejected operation, valid with done |
| cr_valid | output | 1 | Condition field valid |
| cr_out | output | 4 | Condition field {lt, gt, eq, so} |

## Verification
A corrupted accumulator, lane counter or first-element record shows up as a wrong value in the destination register. It can also appear as a write that lands in a masked or unrelated slot. Either is visible on the read port right after `done`. A stuck index or skip decision changes the number of busy cycles of that very run, and a wrong accumulation rule changes the field carried by `cr_valid` within the same run. The bench therefore compares the whole register file, the busy-cycle count and every emitted condition field after each run.

// File: rtl/vreduce_engine.sv
`timescale 1ns/1ps
module vreduce_engine #(
  parameter int EW    = 16,
  parameter int NREG  = 32,
  parameter int VLMAX = 8,
  localparam int AW   = $clog2(NREG),
  localparam int VW   = $clog2(VLMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [EW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [EW-1:0]    rd_data,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [VW-1:0]    vlen,
  input  logic [VLMAX-1:0] pmask,
  input  logic [AW-1:0]    src_base,
  input  logic [AW-1:0]    dst_base,
  input  logic [1:0]       sub_len,
  input  logic             horiz,
  input  logic             cr_en,
  input  logic             cr_all,
  output logic             busy,
  output logic             done,
  output logic             illegal,
  output logic             cr_valid,
  output logic [3:0]       cr_out
);
  localparam int CW = (VW < 2) ? 2 : VW;

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_WRITE, S_FIN} st_t;

  function automatic logic [3:0] cr_of(input logic [EW-1:0] v);
    return {v[EW-1], ~v[EW-1] & (|v), ~(|v), 1'b0};
  endfunction

  logic [EW-1:0]    rf [NREG];
  st_t              st;
  logic [2:0]       op_q;
  logic [VW-1:0]    vl_q;
  logic [VLMAX-1:0] pm_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [1:0]       sv_q;
  logic             hz_q, cre_q, cra_q, ill_q;
  logic [CW-1:0]    o, n, first_q;
  logic             have_q, cmb_q;
  logic [EW-1:0]    acc, rval, opres, nres;
  logic [3:0]       crv;

  logic [VLMAX-1:0] vmask, pm_sh;
  logic             legal, nonempty, act, load, inner_last, outer_last;
  logic [CW-1:0]    vlast;
  logic [AW-1:0]    svn, src_off, wa;
  logic [3:0]       cr_step;

  always_comb
    for (int k = 0; k < VLMAX; k++) vmask[k] = (VW'(k) < vlen);

  assign legal      = (op <= 3'd4);
  assign nonempty   = |(pmask & vmask);
  assign svn        = AW'(sv_q) + AW'(1);
  assign vlast      = CW'(vl_q - VW'(1));
  assign pm_sh      = hz_q ? (pm_q >> o) : (pm_q >> n);
  assign act        = pm_sh[0];
  assign load       = hz_q ? (n == '0) : ~have_q;
  assign inner_last = hz_q ? (n == CW'(sv_q)) : (n == vlast);
  assign outer_last = hz_q ? (o == vlast) : (o == CW'(sv_q));
  assign src_off    = hz_q ? (AW'(o) * svn + AW'(n)) : (AW'(n) * svn + AW'(o));
  assign rval       = rf[src_q + src_off];
  assign wa         = hz_q ? (dst_q + AW'(o)) : (dst_q + AW'(first_q) * svn + AW'(o));

  always_comb begin
    case (op_q)
      3'd0:    opres = acc + rval;
      3'd1:    opres = acc * rval;
      3'd2:    opres = ($signed(rval) < $signed(acc)) ? rval : acc;
      3'd3:    opres = ($signed(rval) > $signed(acc)) ? rval : acc;
      default: opres = acc | rval;
    endcase
  end

  assign nres    = load ? rval : opres;
  assign cr_step = cr_of(opres);

  assign busy     = (st == S_STEP) || (st == S_WRITE);
  assign done     = (st == S_FIN);
  assign illegal  = done && ill_q;
  assign cr_valid = (st == S_WRITE) && cre_q && (hz_q || sv_q == 2'd0);
  assign cr_out   = hz_q ? cr_of(acc) : crv;
  assign rd_data  = rf[rd_addr];

  always_ff @(posedge clk) begin
    if (st == S_WRITE)       rf[wa] <= acc;
    else if (!busy && wr_en) rf[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= '0; vl_q <= '0; pm_q <= '0; src_q <= '0; dst_q <= '0;
      sv_q <= '0; hz_q <= 1'b0; cre_q <= 1'b0; cra_q <= 1'b0; ill_q <= 1'b0;
      o <= '0; n <= '0; first_q <= '0; have_q <= 1'b0; cmb_q <= 1'b0;
      acc <= '0; crv <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q <= op; vl_q <= vlen; pm_q <= pmask & vmask;
          src_q <= src_base; dst_q <= dst_base; sv_q <= sub_len;
          hz_q <= horiz; cre_q <= cr_en; cra_q <= cr_all;
          ill_q <= ~legal;
          o <= '0; n <= '0; have_q <= 1'b0; cmb_q <= 1'b0;
          st <= (legal && nonempty) ? S_STEP : S_FIN;
        end
        S_STEP: begin
          if (hz_q && !act) begin
            if (o == vlast) st <= S_FIN;
            else begin o <= o + CW'(1); n <= '0; end
          end else begin
            if (act) begin
              acc <= nres;
              have_q <= 1'b1;
              if (load) begin
                first_q <= n;
                crv <= cr_of(rval);
                cmb_q <= 1'b0;
              end else if (!cmb_q) begin
                crv <= cr_step;
                cmb_q <= 1'b1;
              end else begin
                crv <= cra_q ? (crv & cr_step) : (crv | cr_step);
              end
            end
            if (inner_last) st <= S_WRITE;
            else n <= n + CW'(1);
          end
        end
        S_WRITE: begin
          if (outer_last) st <= S_FIN;
          else begin
            o <= o + CW'(1); n <= '0; have_q <= 1'b0; st <= S_STEP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module vreduce_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       illegal,
  input logic       cr_valid,
  input logic [3:0] cr_out
);
  AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R10
  AST_START_ACCEPT:   assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && !done) |=> (busy || done)); // R10
  AST_ILLEGAL_DONE:   assert property (@(posedge clk) disable iff (!rst_n) illegal |-> done); // R2
  AST_ILLEGAL_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) illegal |-> !$past(busy)); // R2
  AST_CR_IN_RUN:      assert property (@(posedge clk) disable iff (!rst_n) cr_valid |-> busy); // R6
  AST_CR_SO_ZERO:     assert property (@(posedge clk) disable iff (!rst_n) cr_valid |-> !cr_out[0]); // R6
endmodule

bind vreduce_engine vreduce_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .illegal(illegal), .cr_valid(cr_valid), .cr_out(cr_out)
);

// File: tb/vreduce_engine_tb.sv
`timescale 1ns/1ps
module vreduce_engine_tb;
  localparam int EW = 16, NREG = 32, VLMAX = 8, AW = 5, VW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, src_base = '0, dst_base = '0;
  logic [EW-1:0] wr_data = '0, rd_data;
  logic start = 1'b0;
  logic [2:0] op = '0;
  logic [VW-1:0] vlen = '0;
  logic [VLMAX-1:0] pmask = '0;
  logic [1:0] sub_len = '0;
  logic horiz = 1'b0, cr_en = 1'b0, cr_all = 1'b0;
  logic busy, done, illegal, cr_valid;
  logic [3:0] cr_out;

  vreduce_engine #(.EW(EW), .NREG(NREG), .VLMAX(VLMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .op(op), .vlen(vlen),
    .pmask(pmask), .src_base(src_base), .dst_base(dst_base), .sub_len(sub_len),
    .horiz(horiz), .cr_en(cr_en), .cr_all(cr_all), .busy(busy), .done(done),
    .illegal(illegal), .cr_valid(cr_valid), .cr_out(cr_out));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [EW-1:0] exp_rf [NREG];
  logic [3:0] exp_cr [VLMAX];
  logic [3:0] got_cr [VLMAX];
  int exp_ncr, exp_busy;

  function automatic logic [3:0] an(input logic [EW-1:0] v);
    return {v[EW-1], !v[EW-1] && (v != 0), v == 0, 1'b0};
  endfunction

  function automatic logic [EW-1:0] opf(input int c, input logic [EW-1:0] a, input logic [EW-1:0] b);
    case (c)
      0: return a + b;
      1: return EW'(a * b);
      2: return ($signed(b) < $signed(a)) ? b : a;
      3: return ($signed(b) > $signed(a)) ? b : a;
      default: return a | b;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic load_rf(input int seed);
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(r);
      wr_data = EW'((r * 40503 + seed * 12345 + 7) >> 2);
      exp_rf[r] = wr_data;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic model(input int c, input int vl, input logic [VLMAX-1:0] pm, input int src,
                       input int dst, input int sv, input bit hz, input bit cre, input bit cra);
    int svn;
    logic [EW-1:0] acc, v;
    logic [3:0] crv;
    bit any;
    svn = sv + 1; exp_ncr = 0; exp_busy = 0; any = 0;
    for (int i = 0; i < vl; i++) if (pm[i]) any = 1;
    if (c > 4 || !any) return;
    if (!hz) begin
      exp_busy = svn * (vl + 1);
      for (int j = 0; j < svn; j++) begin
        bit have, cmb; int first;
        have = 0; cmb = 0; first = 0; acc = '0; crv = '0;
        for (int i = 0; i < vl; i++) if (pm[i]) begin
          v = exp_rf[(src + i * svn + j) % NREG];
          if (!have) begin acc = v; first = i; have = 1; crv = an(v); end
          else begin
            acc = opf(c, acc, v);
            if (!cmb) begin crv = an(acc); cmb = 1; end
            else crv = cra ? (crv & an(acc)) : (crv | an(acc));
          end
        end
        exp_rf[(dst + first * svn + j) % NREG] = acc;
        if (cre && svn == 1) begin exp_cr[exp_ncr] = crv; exp_ncr++; end
      end
    end else begin
      for (int i = 0; i < vl; i++) begin
        if (!pm[i]) begin exp_busy += 1; continue; end
        exp_busy += svn + 1;
        acc = exp_rf[(src + i * svn) % NREG];
        for (int k = 1; k < svn; k++) acc = opf(c, acc, exp_rf[(src + i * svn + k) % NREG]);
        exp_rf[(dst + i) % NREG] = acc;
        if (cre) begin exp_cr[exp_ncr] = an(acc); exp_ncr++; end
      end
    end
  endtask

  task automatic run(input int c, input int vl, input logic [VLMAX-1:0] pm, input int src,
                     input int dst, input int sv, input bit hz, input bit cre, input bit cra,
                     input bit poke, input string req);
    int nb, ncr, guard;
    bit first_it;
    logic [EW-1:0] poke_val;
    model(c, vl, pm, src, dst, sv, hz, cre, cra);
    poke_val = ~exp_rf[NREG-1];
    @(negedge clk);
    op = 3'(c); vlen = VW'(vl); pmask = pm; src_base = AW'(src); dst_base = AW'(dst);
    sub_len = 2'(sv); horiz = hz; cr_en = cre; cr_all = cra; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nb = 0; ncr = 0; guard = 0; first_it = 1'b1;
    while (!done && guard < 1000) begin
      if (busy) nb++;
      if (cr_valid) begin
        if (ncr < VLMAX) got_cr[ncr] = cr_out;
        ncr++;
      end
      if (first_it && poke) begin
        wr_en = 1'b1; wr_addr = AW'(NREG - 1); wr_data = poke_val;
      end
      first_it = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
      guard++;
    end
    check(done == 1'b1, "R10", {req, " done seen"}, done, 1);
    check(illegal == (c > 4), "R2", {req, " illegal flag"}, illegal, c > 4);
    check(nb == exp_busy, "R10", {req, " busy cycles"}, nb, exp_busy);
    check(ncr == exp_ncr, "R6", {req, " condition count"}, ncr, exp_ncr);
    for (int k = 0; k < exp_ncr && k < ncr; k++)
      check(got_cr[k] == exp_cr[k], "R6,R7", {req, " condition field"}, got_cr[k], exp_cr[k]);
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      rd_addr = AW'(r);
      #1;
      check(rd_data == exp_rf[r], req, $sformatf("reg %0d", r), rd_data, exp_rf[r]);
    end
  endtask

  initial begin
    logic [VLMAX-1:0] masks [5];
    int seed;
    masks[0] = 8'hFF; masks[1] = 8'hA6; masks[2] = 8'h01; masks[3] = 8'h80; masks[4] = 8'h5A;
    seed = 0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && cr_valid == 1'b0, "R10", "reset outputs",
          {busy, done, cr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R10", "idle after reset", {busy, done}, 0);

    for (int c = 0; c < 5; c++)
      for (int sv = 0; sv < 4; sv++)
        for (int hz = 0; hz < 2; hz++)
          for (int m = 0; m < 5; m++)
            for (int cra = 0; cra < 2; cra++) begin
              int vl;
              vl = (m == 4) ? 5 : VLMAX;
              seed++;
              load_rf(seed);
              run(c, vl, masks[m], (seed % 3), (sv == 0) ? 16 + (seed % 5) : 0, sv, hz[0], 1'b1,
                  cra[0], 1'b0,
                  hz ? "R9" : (sv != 0 ? "R8" : "R1,R3,R4"));
            end

    load_rf(900);
    run(0, 6, 8'h34, 2, 12, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R3,R4 sparse mask");
    load_rf(901);
    run(2, 8, 8'hF0, 0, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R1,R4 min upper half");
    for (int c = 5; c < 8; c++) begin
      load_rf(910 + c);
      run(c, 8, 8'hFF, 0, 16, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
    end
    load_rf(920);
    run(0, 8, 8'h00, 0, 16, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 empty mask");
    load_rf(921);
    run(0, 0, 8'hFF, 0, 16, 0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 zero length");
    load_rf(922);
    run(4, 4, 8'hF0, 0, 16, 1, 1'b0, 1'b1, 1'b0, 1'b0, "R5 mask beyond length");
    load_rf(930);
    run(3, 8, 8'hFF, 0, 16, 0, 1'b0, 1'b1, 1'b1, 1'b1, "R11");
    load_rf(931);
    run(1, 8, 8'hFF, 0, 8, 2, 1'b1, 1'b1, 1'b0, 1'b1, "R11,R9");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule